// File: doc/BRIEF.md
# DMA Bus Error Address Capture

This block sits beside a DMA master that cuts each DMA transfer into bus bursts of 256 bytes and can have many of those bursts in flight at once. When a transfer begins, the master hands the block a transfer tag, the 64-bit start address and the length in bytes. Every burst response comes back carrying the tag of its parent transfer. The block keeps one small entry per tag, holding only the start address and the number of responses still owed. It keeps no per-burst address.

When any response for an active transfer carries an error, the block latches the start address of that whole transfer, whichever burst failed. It then raises a sticky valid flag. In host mode it also raises a sticky system-error line; in device mode the valid flag is the only sign. Only the first error is kept until software clears the flag. Software reads the address through two read-only 32-bit words, low and high.

Top module: `bus_err_addr_cap`

## Requirements
- R1: After reset, `err_vld_o` and `sys_err_o` are 0 and both address words read 0.
- R2: A start pulse with length L loads the tag's entry with the start address and ceil(L/256) owed responses. A start with L = 0 is ignored. An entry loaded with L = 257 owes exactly 2 responses.
- R3: An error response (`rsp_valid_i` and `rsp_err_i`) whose tag has an active entry sets `err_vld_o` at the next clock edge. It also captures that entry's start address, whichever burst of the transfer failed.
- R4: An entry is freed by the response that pays its last owed burst. Responses for tags with no active entry, error or not, change nothing.
- R5: While `err_vld_o` is 1, further error responses leave the address words and the flags unchanged.
- R6: `err_clr_i` without a same-cycle error clears `err_vld_o` and `sys_err_o` at the next edge. The address words keep their last captured value.
- R7: When `err_clr_i` and an error on an active tag fall in the same cycle, the new address is captured and `err_vld_o` stays 1.
- R8: If `host_mode_i` is 1 when an error is captured, `sys_err_o` rises together with `err_vld_o`. If it is 0, `sys_err_o` stays 0. `sys_err_o` is never 1 while `err_vld_o` is 0.
- R9: `err_addr_lo_o` carries address bits 31:0 and `err_addr_hi_o` carries bits 63:32.
- R10: Several transfers may be active under different tags with interleaved responses. Each keeps its own start address and owed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | 1 = host mode, 0 = device mode |
| xfer_start_i | input | 1 | Start of a DMA transfer |
| xfer_tag_i | input | TAG_W (3) | Tag of the starting transfer |
| xfer_addr_i | input | 64 | Start address of the transfer |
| xfer_len_i | input | LEN_W (16) | Transfer length in bytes |
| rsp_valid_i | input | 1 | Burst response strobe |
| rsp_tag_i | input | TAG_W (3) | Parent tag of the responding burst |
| rsp_err_i | input | 1 | Response is an error |
| err_clr_i | input | 1 | Software clear of the error flags |
| err_vld_o | output | 1 | Sticky captured-address valid |
| sys_err_o | output | 1 | Sticky system error, host mode only |
| err_addr_lo_o | output | 32 | Captured address bits 31:0 |
| err_addr_hi_o | output | 32 | Captured address bits 63:32 |

## Verification
Two functions can land in the same cycle: software clearing the flags, and a new error response arriving. The bench sets up this collision by leaving the valid flag set from an earlier capture. It then raises `err_clr_i` together with an error response on a second, still active tag. The result is correct only if the flag stays high and the address words switch to the second transfer's start address. A clear-only cycle is run against it, and that one must drop both flags.

// File: rtl/bea_pkg.sv
package bea_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 2 * WORD_W;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bea_burst_calc.sv
module bea_burst_calc #(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned BURST_SH = 8,
  localparam int unsigned CNT_W   = LEN_W - BURST_SH + 1
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [LEN_W:0] ROUND = (LEN_W+1)'((1 << BURST_SH) - 1);
  logic [LEN_W:0] sum;
  // ceil(len / burst)
  assign sum   = {1'b0, len_i} + ROUND;
  assign cnt_o = sum[LEN_W:BURST_SH];
endmodule

// File: rtl/bea_xfer_table.sv
module bea_xfer_table
  import bea_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 8,
  parameter int unsigned CNT_W    = 9,
  localparam int unsigned TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] start_tag_i,
  input  addr_t            start_addr_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic             rsp_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  output logic             hit_o,
  output addr_t            hit_addr_o
);
  logic [NUM_TAGS-1:0] vld_q;
  addr_t               addr_q [NUM_TAGS];
  logic [CNT_W-1:0]    rem_q  [NUM_TAGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < NUM_TAGS; i++) begin
        addr_q[i] <= '0;
        rem_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (start_i && start_tag_i == TAG_W'(i) && start_cnt_i != '0) begin
          vld_q[i]  <= 1'b1;
          addr_q[i] <= start_addr_i;
          rem_q[i]  <= start_cnt_i;
        end else if (rsp_i && rsp_tag_i == TAG_W'(i) && vld_q[i]) begin
          rem_q[i] <= rem_q[i] - 1'b1;
          if (rem_q[i] == CNT_W'(1)) vld_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    hit_o      = 1'b0;
    hit_addr_o = '0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (rsp_tag_i == TAG_W'(i)) begin
        hit_o      = rsp_i && vld_q[i];
        hit_addr_o = addr_q[i];
      end
    end
  end
endmodule

// File: rtl/bea_first_capture.sv
module bea_first_capture
  import bea_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  err_i,
  input  addr_t err_addr_i,
  input  logic  host_i,
  input  logic  clr_i,
  output logic  vld_o,
  output logic  host_err_o,
  output addr_t addr_o
);
  logic  vld_q, host_q;
  addr_t addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      host_q <= 1'b0;
      addr_q <= '0;
    end else if (err_i && (!vld_q || clr_i)) begin
      // clear and new error together: the new error wins
      vld_q  <= 1'b1;
      host_q <= host_i;
      addr_q <= err_addr_i;
    end else if (clr_i) begin
      vld_q  <= 1'b0;
      host_q <= 1'b0;
    end
  end

  assign vld_o      = vld_q;
  assign host_err_o = host_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/bus_err_addr_cap.sv
module bus_err_addr_cap
  import bea_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 8,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned BURST_SH = 8,
  localparam int unsigned TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
  localparam int unsigned CNT_W   = LEN_W - BURST_SH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_mode_i,
  input  logic             xfer_start_i,
  input  logic [TAG_W-1:0] xfer_tag_i,
  input  logic [63:0]      xfer_addr_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  input  logic             rsp_valid_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  input  logic             rsp_err_i,
  input  logic             err_clr_i,
  output logic             err_vld_o,
  output logic             sys_err_o,
  output logic [31:0]      err_addr_lo_o,
  output logic [31:0]      err_addr_hi_o
);
  logic [CNT_W-1:0] start_cnt;
  logic             tbl_hit;
  logic             err_hit;
  addr_t            hit_addr;
  addr_t            cap_addr;

  bea_burst_calc #(.LEN_W(LEN_W), .BURST_SH(BURST_SH)) u_calc (
    .len_i (xfer_len_i),
    .cnt_o (start_cnt)
  );

  bea_xfer_table #(.NUM_TAGS(NUM_TAGS), .CNT_W(CNT_W)) u_tbl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (xfer_start_i),
    .start_tag_i  (xfer_tag_i),
    .start_addr_i (xfer_addr_i),
    .start_cnt_i  (start_cnt),
    .rsp_i        (rsp_valid_i),
    .rsp_tag_i    (rsp_tag_i),
    .hit_o        (tbl_hit),
    .hit_addr_o   (hit_addr)
  );

  assign err_hit = tbl_hit && rsp_err_i;

  bea_first_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_i      (err_hit),
    .err_addr_i (hit_addr),
    .host_i     (host_mode_i),
    .clr_i      (err_clr_i),
    .vld_o      (err_vld_o),
    .host_err_o (sys_err_o),
    .addr_o     (cap_addr)
  );

  assign err_addr_lo_o = cap_addr[WORD_W-1:0];
  assign err_addr_hi_o = cap_addr[ADDR_W-1:WORD_W];
endmodule

// File: rtl/bus_err_addr_cap_chk.sv
module bus_err_addr_cap_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_mode_i,
  input logic        err_clr_i,
  input logic        err_hit,
  input logic [63:0] hit_addr,
  input logic        err_vld_o,
  input logic        sys_err_o,
  input logic [31:0] err_addr_lo_o,
  input logic [31:0] err_addr_hi_o
);
  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hit && !err_vld_o |=> err_vld_o && {err_addr_hi_o, err_addr_lo_o} == $past(hit_addr));

  a_r5_first_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o && !err_clr_i |=> err_vld_o && $stable({err_addr_hi_o, err_addr_lo_o}) && $stable(sys_err_o));

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !err_hit |=> !err_vld_o && !sys_err_o && $stable({err_addr_hi_o, err_addr_lo_o}));

  a_r7_clear_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && err_hit |=> err_vld_o && {err_addr_hi_o, err_addr_lo_o} == $past(hit_addr));

  a_r8_dev_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hit && (!err_vld_o || err_clr_i) && !host_mode_i |=> !sys_err_o);

  a_r8_host_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hit && (!err_vld_o || err_clr_i) && host_mode_i |=> sys_err_o);

  a_r8_sys_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_err_o |-> err_vld_o);
endmodule

bind bus_err_addr_cap bus_err_addr_cap_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_mode_i   (host_mode_i),
  .err_clr_i     (err_clr_i),
  .err_hit       (err_hit),
  .hit_addr      (hit_addr),
  .err_vld_o     (err_vld_o),
  .sys_err_o     (sys_err_o),
  .err_addr_lo_o (err_addr_lo_o),
  .err_addr_hi_o (err_addr_hi_o)
);

// File: tb/sim_bus_err_addr_cap.sv
module sim_bus_err_addr_cap;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 3;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_mode = 1'b1;
  logic             xs = 1'b0;
  logic [TAG_W-1:0] xtag = '0;
  logic [63:0]      xaddr = '0;
  logic [LEN_W-1:0] xlen = '0;
  logic             rv = 1'b0;
  logic [TAG_W-1:0] rtag = '0;
  logic             rerr = 1'b0;
  logic             clr = 1'b0;
  logic             vld, syserr;
  logic [31:0]      lo, hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_err_addr_cap u0 (
    .clk_i (clk), .rst_ni (rst_n), .host_mode_i (host_mode),
    .xfer_start_i (xs), .xfer_tag_i (xtag), .xfer_addr_i (xaddr), .xfer_len_i (xlen),
    .rsp_valid_i (rv), .rsp_tag_i (rtag), .rsp_err_i (rerr), .err_clr_i (clr),
    .err_vld_o (vld), .sys_err_o (syserr), .err_addr_lo_o (lo), .err_addr_hi_o (hi)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic ev, input logic es, input logic [63:0] ea);
    chk({req, " vld"}, 64'(vld), 64'(ev));
    chk({req, " sys"}, 64'(syserr), 64'(es));
    chk({req, " addr"}, {hi, lo}, ea);
  endtask

  // one cycle of stimulus, launched at a negedge, results visible at the next negedge
  task automatic step(input logic s, input int t, input logic [63:0] a, input int l,
                      input logic r, input int rt, input logic e, input logic c);
    xs = s; xtag = TAG_W'(t); xaddr = a; xlen = LEN_W'(l);
    rv = r; rtag = TAG_W'(rt); rerr = e; clr = c;
    @(negedge clk);
    xs = 1'b0; rv = 1'b0; rerr = 1'b0; clr = 1'b0;
  endtask

  task automatic start(input int t, input logic [63:0] a, input int l);
    step(1'b1, t, a, l, 1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic rsp(input int t, input logic e);
    step(1'b0, 0, 64'd0, 0, 1'b1, t, e, 1'b0);
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 1'b0, 1'b0, 64'd0);
  endtask

  task automatic t_third_burst;
    host_mode = 1'b1;
    start(2, 64'h0000_0000_ABCD_0000, 1024);
    start(5, 64'h0000_0001_2345_6700, 512);
    rsp(2, 1'b0);
    rsp(5, 1'b0);
    rsp(2, 1'b0);
    chk_state("R10 no error yet", 1'b0, 1'b0, 64'd0);
    rsp(2, 1'b1);
    chk_state("R3 third burst host", 1'b1, 1'b1, 64'h0000_0000_ABCD_0000);
    chk("R9 low word", 64'(lo), 64'hABCD_0000);
    rsp(5, 1'b1);
    chk_state("R5 later error kept out", 1'b1, 1'b1, 64'h0000_0000_ABCD_0000);
    rsp(2, 1'b0);
  endtask

  task automatic t_clear_and_free;
    step(1'b0, 0, 64'd0, 0, 1'b0, 0, 1'b0, 1'b1);
    chk_state("R6 clear", 1'b0, 1'b0, 64'h0000_0000_ABCD_0000);
    rsp(2, 1'b1);
    chk_state("R4 freed tag 2", 1'b0, 1'b0, 64'h0000_0000_ABCD_0000);
    rsp(5, 1'b1);
    chk_state("R4 freed tag 5", 1'b0, 1'b0, 64'h0000_0000_ABCD_0000);
    rsp(0, 1'b1);
    chk_state("R4 never used tag", 1'b0, 1'b0, 64'h0000_0000_ABCD_0000);
  endtask

  task automatic t_device;
    host_mode = 1'b0;
    start(1, 64'hFEDC_BA98_7654_3210, 300);
    rsp(1, 1'b1);
    chk_state("R8 device mode", 1'b1, 1'b0, 64'hFEDC_BA98_7654_3210);
    chk("R9 high word", 64'(hi), 64'hFEDC_BA98);
    rsp(1, 1'b0);
  endtask

  task automatic t_collide;
    host_mode = 1'b1;
    start(3, 64'h0000_0042_1000_0000, 256);
    start(4, 64'h0000_0077_2000_0100, 256);
    step(1'b0, 0, 64'd0, 0, 1'b1, 3, 1'b1, 1'b1);
    chk_state("R7 clear with error", 1'b1, 1'b1, 64'h0000_0042_1000_0000);
    step(1'b0, 0, 64'd0, 0, 1'b0, 0, 1'b0, 1'b1);
    chk_state("R6 clear only", 1'b0, 1'b0, 64'h0000_0042_1000_0000);
  endtask

  task automatic t_lengths;
    start(6, 64'h0000_0000_5555_0000, 0);
    rsp(6, 1'b1);
    chk_state("R2 zero length ignored", 1'b0, 1'b0, 64'h0000_0042_1000_0000);
    start(7, 64'h0000_0000_6666_0000, 257);
    rsp(7, 1'b0);
    rsp(7, 1'b0);
    rsp(7, 1'b1);
    chk_state("R2 257 bytes owes two", 1'b0, 1'b0, 64'h0000_0042_1000_0000);
    rsp(4, 1'b1);
    chk_state("R10 other tag intact", 1'b1, 1'b1, 64'h0000_0077_2000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_third_burst();
    t_clear_and_free();
    t_device();
    t_collide();
    t_lengths();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule